// File: doc/BRIEF.md
# Buck Stage PWM Generator with Dead Time

This block turns a per-period duty count into the two gate enables of a synchronous buck power stage: a high-side enable and a complementary low-side enable. A free-running counter sets the switching period (200 clock counts, a 500 kHz switching rate from a 100 MHz clock). The high side is demanded from the start of a period until the latched on-count runs out, and the low side is demanded for the rest of the period. An interlock keeps either gate from turning on until both have been low for a programmable number of clocks. This gap applies to every transition in both directions.

The duty count is sampled once per period, on the clock edge that starts the period. Commands above the upper limit are cut to that limit. Commands below the lower limit are not widened on every period. They are summed across periods instead, and a minimum-width pulse is issued only when the running sum reaches the limit. This lowers the average duty by dropping whole pulses. Two override inputs take precedence over the counter. One holds the low side on, for example during a cycle-by-cycle overcurrent. The other holds both switches off. The dead-time interlock still governs both overrides. A single-cycle strobe marks the first cycle of each period.

Top module: `buck_pwm_dt`

## Requirements
- R1: `period_start` is high for exactly one cycle in every 200. The first pulse is in the first cycle after reset is released.
- R2: `hs_en` and `ls_en` are never both high in the same cycle.
- R3: A gate output may rise only after both outputs have been low for the previous cycle. With a duty count D at or above the minimum, `hs_en` plus `ls_en` is high for 198 of the 200 cycles in a period.
- R4: For a latched count D with 20 <= D <= 186, `hs_en` is high for D-1 cycles. These are cycles 2 through D of the period, where cycle 0 is the one in which `period_start` is high.
- R5: A command above 186 (for example 250) acts as 186, so the high side is high for 185 cycles.
- R6: A command below 20 is added to a carried sum. A period gets a 20-count pulse (19 high cycles) when the sum reaches 20, and 20 is then subtracted. Otherwise the period has no pulse and the low side stays on for all 200 cycles. A command of 10 alternates skipped and pulsed periods, starting with a skipped period, and a command of 0 never pulses.
- R7: The duty count is sampled only on the edge that begins a period. A change in the middle of a period leaves that period's high time unchanged and takes effect in the next period.
- R8: While `force_ls` is high and `force_off` is low, `hs_en` is low from the next cycle. `ls_en` rises one cycle after that if the high side was on.
- R9: While `force_off` is high, both outputs are low from the next cycle.
- R10: `force_off` takes priority when both overrides are high: both gates stay low.
- R11: During reset, `hs_en`, `ls_en` and `period_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 8 | Requested high-side on-count per period |
| force_ls | input | 1 | Hold the low side on and the high side off |
| force_off | input | 1 | Hold both gates off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| period_start | output | 1 | High during the first cycle of each period |

## Verification
Embedded properties check the following on every cycle: the gates are never on together, no gate rises without a preceding cycle with both gates low, the overrides take effect after one cycle, the counter stays in range, and the latched on-count is either zero or between the two limits. The exact pulse widths, the clamp, the skip pattern of the carried sum, the deferral of a mid-period command change and the strobe spacing can only be shown by the bench's scenarios. For these, the bench compares the outputs against a behavioural model on every clock and counts the high cycles in each period.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;
  typedef enum logic [1:0] {
    GATE_RUN     = 2'd0,
    GATE_LS_HOLD = 2'd1,
    GATE_ALL_OFF = 2'd2
  } gate_mode_e;

  function automatic gate_mode_e pick_mode(input logic off_req, input logic ls_req);
    if (off_req)     return GATE_ALL_OFF;
    else if (ls_req) return GATE_LS_HOLD;
    else             return GATE_RUN;
  endfunction
endpackage

// File: rtl/buck_pwm_timer.sv
module buck_pwm_timer #(
  parameter int PERIOD = 200,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    start_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= LAST;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign load_o  = wrap;
  assign start_o = start_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == '0)); // R1
endmodule

// File: rtl/buck_pwm_shaper.sv
module buck_pwm_shaper #(
  parameter int DUTY_W   = 8,
  parameter int DUTY_MIN = 20,
  parameter int DUTY_MAX = 186
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_cmd,
  output logic [DUTY_W-1:0] on_cnt
);
  localparam int ACC_W = DUTY_W + 1;
  localparam logic [DUTY_W-1:0] MIN_L  = DUTY_W'(DUTY_MIN);
  localparam logic [DUTY_W-1:0] MAX_L  = DUTY_W'(DUTY_MAX);
  localparam logic [ACC_W-1:0]  MIN_AL = ACC_W'(DUTY_MIN);

  logic [DUTY_W-1:0] on_q, on_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [ACC_W-1:0]  sum;

  always_comb begin
    on_d  = on_q;
    acc_d = acc_q;
    sum   = acc_q + ACC_W'(duty_cmd);
    if (load) begin
      if (duty_cmd >= MIN_L) begin
        on_d = (duty_cmd > MAX_L) ? MAX_L : duty_cmd;
      end else if (sum >= MIN_AL) begin
        on_d  = MIN_L;
        acc_d = sum - MIN_AL;
      end else begin
        on_d  = '0;
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      acc_q <= '0;
    end else if (load) begin
      on_q  <= on_d;
      acc_q <= acc_d;
    end
  end

  assign on_cnt = on_q;

  AST_ON_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q == '0) || ((on_q >= MIN_L) && (on_q <= MAX_L))); // R5
  AST_ACC_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < MIN_AL); // R6
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(on_q)); // R7
endmodule

// File: rtl/buck_pwm_gate.sv
module buck_pwm_gate
  import buck_pwm_pkg::*;
#(
  parameter int DEAD_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gate_mode_e mode,
  input  logic       pwm_hs,
  output logic       hs_en,
  output logic       ls_en
);
  logic hs_want, ls_want;
  logic hs_q, ls_q, hs_d, ls_d;
  logic gap_ok;

  always_comb begin
    unique case (mode)
      GATE_ALL_OFF: begin hs_want = 1'b0;   ls_want = 1'b0;    end
      GATE_LS_HOLD: begin hs_want = 1'b0;   ls_want = 1'b1;    end
      default:      begin hs_want = pwm_hs; ls_want = !pwm_hs; end
    endcase
    hs_d = hs_want && !ls_q && (hs_q || gap_ok);
    ls_d = ls_want && !hs_q && (ls_q || gap_ok);
  end

  generate
    if (DEAD_CYC == 0) begin : g_no_gap
      assign gap_ok = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(DEAD_CYC + 1);
      localparam logic [GW-1:0] GAP_L = GW'(DEAD_CYC);
      logic [GW-1:0] off_q, off_d;
      always_comb begin
        if (hs_d || ls_d)       off_d = '0;
        else if (off_q < GAP_L) off_d = off_q + 1'b1;
        else                    off_d = off_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
      end
      assign gap_ok = (off_q >= GAP_L);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q)); // R2
  AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(!hs_q && !ls_q)); // R3
  AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> $past(!hs_q && !ls_q)); // R3
  AST_LS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_LS_HOLD) |=> !hs_q); // R8
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_ALL_OFF) |=> (!hs_q && !ls_q)); // R9
endmodule

// File: rtl/buck_pwm_dt.sv
module buck_pwm_dt
  import buck_pwm_pkg::*;
#(
  parameter int PERIOD   = 200,
  parameter int DUTY_W   = 8,
  parameter int DUTY_MIN = 20,
  parameter int DUTY_MAX = 186,
  parameter int DEAD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              force_ls,
  input  logic              force_off,
  output logic              hs_en,
  output logic              ls_en,
  output logic              period_start
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic [CNT_W-1:0]  cnt;
  logic              load;
  logic [DUTY_W-1:0] on_cnt;
  logic              pwm_hs;
  gate_mode_e        mode;

  buck_pwm_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .load_o(load), .start_o(period_start)
  );

  buck_pwm_shaper #(.DUTY_W(DUTY_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_shaper (
    .clk(clk), .rst_n(rst_n), .load(load), .duty_cmd(duty_cmd), .on_cnt(on_cnt)
  );

  always_comb begin
    pwm_hs = (CMP_W'(cnt) < CMP_W'(on_cnt));
    mode   = pick_mode(force_off, force_ls);
  end

  buck_pwm_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwm_hs(pwm_hs), .hs_en(hs_en), .ls_en(ls_en)
  );

  AST_OFF_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off && force_ls) |=> !ls_en); // R10
endmodule

// File: tb/test_buck_pwm_dt.sv
module test_buck_pwm_dt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] duty_cmd;
  logic       force_ls, force_off;
  logic       hs_en, ls_en, period_start;

  always #4 clk = ~clk;

  buck_pwm_dt i_buck_pwm_dt (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .force_ls(force_ls),
    .force_off(force_off), .hs_en(hs_en), .ls_en(ls_en), .period_start(period_start)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_on, m_acc, m_off;
  bit m_hs, m_ls, m_ps;
  always @(posedge clk) begin
    bit hw, lw, nh, nl;
    int s;
    if (!rst_n) begin
      m_cnt = 199; m_on = 0; m_acc = 0; m_off = 0; m_hs = 0; m_ls = 0; m_ps = 0;
    end else begin
      if (force_off)     begin hw = 0; lw = 0; end
      else if (force_ls) begin hw = 0; lw = 1; end
      else begin hw = (m_cnt < m_on); lw = !hw; end
      nh = hw && !m_ls && (m_hs || m_off >= 1);
      nl = lw && !m_hs && (m_ls || m_off >= 1);
      m_off = (nh || nl) ? 0 : 1;
      m_hs = nh; m_ls = nl;
      if (m_cnt == 199) begin
        m_cnt = 0;
        if (duty_cmd >= 20) m_on = (duty_cmd > 186) ? 186 : int'(duty_cmd);
        else begin
          s = m_acc + int'(duty_cmd);
          if (s >= 20) begin m_on = 20; m_acc = s - 20; end
          else begin m_on = 0; m_acc = s; end
        end
      end else m_cnt++;
      m_ps = (m_cnt == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hs_en == m_hs, "R4", "model hs_en", hs_en, m_hs);
      chk(ls_en == m_ls, "R3", "model ls_en", ls_en, m_ls);
      chk(period_start == m_ps, "R1", "model period_start", period_start, m_ps);
    end
  end

  task automatic measure(input int chg_at, input logic [7:0] nd, output int hs_n, output int ls_n);
    hs_n = 0; ls_n = 0;
    do @(negedge clk); while (!period_start);
    for (int i = 0; i < 200; i++) begin
      hs_n += hs_en; ls_n += ls_en;
      if (i == chg_at) duty_cmd = nd;
      if (i < 199) @(negedge clk);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait_cycles(150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int h, l, gap, hi;
    rst_n = 0; duty_cmd = 8'd100; force_ls = 0; force_off = 0;
    wait_cycles(3);
    chk(!hs_en && !ls_en && !period_start, "R11", "outputs in reset", {hs_en, ls_en, period_start}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(period_start == 1, "R1", "first strobe after reset", period_start, 1);

    measure(-1, 0, h, l);
    chk(h == 99, "R4", "hs cycles duty 100", h, 99);
    chk(h + l == 198, "R3", "gated cycles per period", h + l, 198);

    // R1 strobe spacing
    do @(negedge clk); while (!period_start);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!period_start);
    chk(gap == 200, "R1", "strobe spacing", gap, 200);

    // R7 mid-period change
    measure(50, 8'd40, h, l);
    chk(h == 99, "R7", "hs cycles after mid change", h, 99);
    measure(-1, 0, h, l);
    chk(h == 39, "R7", "hs cycles next period", h, 39);

    duty_cmd = 8'd250;
    measure(-1, 0, h, l);
    chk(h == 185, "R5", "hs cycles duty 250", h, 185);
    duty_cmd = 8'd186;
    measure(-1, 0, h, l);
    chk(h == 185, "R5", "hs cycles duty 186", h, 185);
    duty_cmd = 8'd20;
    measure(-1, 0, h, l);
    chk(h == 19, "R4", "hs cycles duty 20", h, 19);

    // R6 pulse skipping
    duty_cmd = 8'd10;
    measure(-1, 0, h, l);
    chk(h == 0 && l == 200, "R6", "duty 10 first period skipped", h, 0);
    measure(-1, 0, h, l);
    chk(h == 19, "R6", "duty 10 second period pulse", h, 19);
    measure(-1, 0, h, l);
    chk(h == 0, "R6", "duty 10 third period skipped", h, 0);
    measure(-1, 0, h, l);
    chk(h == 19, "R6", "duty 10 fourth period pulse", h, 19);
    duty_cmd = 8'd0;
    measure(-1, 0, h, l);
    measure(-1, 0, h, l);
    chk(h == 0 && l == 200, "R6", "duty 0 low side all period", l, 200);

    // R8 force low side mid pulse
    duty_cmd = 8'd100;
    measure(-1, 0, h, l);
    do @(negedge clk); while (!period_start);
    wait_cycles(30);
    chk(hs_en == 1, "R8", "hs on before force", hs_en, 1);
    force_ls = 1;
    @(negedge clk);
    chk(!hs_en && !ls_en, "R8", "both off in gap", {hs_en, ls_en}, 0);
    @(negedge clk);
    chk(ls_en == 1 && !hs_en, "R8", "low side held", {hs_en, ls_en}, 1);
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); hi += hs_en; end
    chk(hi == 0, "R8", "hs high cycles while forced", hi, 0);
    force_ls = 0;
    measure(-1, 0, h, l);
    measure(-1, 0, h, l);
    chk(h == 99, "R8", "recovery after release", h, 99);

    // R9 force all off
    do @(negedge clk); while (!period_start);
    wait_cycles(30);
    force_off = 1;
    @(negedge clk);
    chk(!hs_en && !ls_en, "R9", "both off next cycle", {hs_en, ls_en}, 0);
    hi = 0;
    for (int i = 0; i < 250; i++) begin @(negedge clk); hi += hs_en + ls_en; end
    chk(hi == 0, "R9", "gate high cycles while off", hi, 0);

    // R10 both overrides
    force_ls = 1;
    hi = 0;
    for (int i = 0; i < 250; i++) begin @(negedge clk); hi += hs_en + ls_en; end
    chk(hi == 0, "R10", "gate high cycles with both overrides", hi, 0);
    force_off = 0;
    wait_cycles(2);
    chk(ls_en == 1 && !hs_en, "R10", "low side after off released", {hs_en, ls_en}, 1);
    force_ls = 0;
    measure(-1, 0, h, l);
    measure(-1, 0, h, l);
    chk(h == 99 && h + l == 198, "R3", "normal after overrides", h + l, 198);

    finish_run();
  end
endmodule